// File: doc/BRIEF.md
# DRAM Refresh Row Scheduler

This block makes sure that every row of a dynamic memory array is refreshed again before its cells lose their charge. A row is refreshed by reading it without using the data. That read restores every cell along the row. The read is destructive, so the sense amplifiers write the value back as part of it. The scheduler is given the retention period and the row count, both in clock cycles. From these it works out a fixed spacing between refreshes, so that the whole array is covered once per retention period. With 8192 rows, a 3 ms period and 10 ns per row, refresh takes about 2.7 % of the array's time.

A free-running interval timer counts out that spacing. Each time the timer expires, one refresh is owed. While any refresh is owed and none is in flight, the block raises a request to the access controller and presents the row to refresh. A grant starts the row cycle. From then until the done pulse, the block asserts a write-block output so that no write reaches the array. When done arrives, the row pointer moves on, wrapping after the last row. A small saturating counter records expiries that occur while earlier refreshes are still waiting, so a slow grant delays a row's refresh but does not skip it.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ref_req` and `wr_block` are 0 and `ref_row` is 0. Reset is taken in asynchronously and released through a two-stage synchronizer, so the block leaves reset on the second rising edge after `rst_n` goes high.
- R2: The interval is INTERVAL = RETENTION_CYC / ROWS cycles. The first expiry raises `ref_req` exactly INTERVAL edges after the reset release. After that, expiries follow every INTERVAL edges whatever the request traffic.
- R3: While `ref_req` is 1 and `ref_grant` is 0, `ref_req` stays 1 and `ref_row` stays unchanged.
- R4: A cycle with `ref_req` = 1 and `ref_grant` = 1 starts a row cycle. In the next cycle `ref_req` is 0 and `wr_block` is 1. `wr_block` stays 1 until the cycle after `ref_done` is seen.
- R5: `ref_row` advances by one only when `ref_done` is seen during a row cycle. A `ref_done` pulse outside a row cycle leaves the row pointer and all outputs unchanged.
- R6: After row ROWS-1 has been refreshed, the row pointer returns to 0.
- R7: Expiries that occur while refreshes are pending are counted. After each done, `ref_req` is raised again in the next cycle if refreshes are still owed. This includes the case where an expiry and a done fall in the same cycle.
- R8: The owed count saturates at 2^OWED_W - 1. Any further expiry at that level is dropped.
- R9: A `ref_grant` while `ref_req` is 0 is ignored: no row cycle starts and `wr_block` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_req | output | 1 | A refresh is owed and no row cycle is running |
| ref_row | output | ROW_W | Row to refresh next |
| ref_grant | input | 1 | Access controller accepts the request |
| ref_done | input | 1 | Dummy row read and restore has completed |
| wr_block | output | 1 | Row cycle in progress; writes must be held off |

## Verification
The bench runs with four rows and a ten-cycle interval. It first services a request promptly, which separates correct interval timing and single-step advance from off-by-one timer or pointer faults. It then leaves requests unanswered for four intervals before servicing them back to back. This separates accumulation, saturation and wrap-around from designs that drop or over-count owed refreshes. Stray grant and done pulses outside a row cycle show whether the handshake state can be corrupted. A done that coincides with an expiry checks that the owed count is incremented and decremented in the same cycle.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_BUSY = 1'b1
  } slot_e;

  function automatic int unsigned interval_of(input int unsigned retention_cyc,
                                              input int unsigned rows);
    return retention_cyc / rows;
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int unsigned INTERVAL = 366,
  localparam int unsigned TMR_W = $clog2(INTERVAL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic expire
);

  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_d;

  always_comb begin
    expire = (cnt_q == TMR_W'(INTERVAL - 1));
    cnt_d  = expire ? '0 : cnt_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/refresh_owed.sv
module refresh_owed #(
  parameter int unsigned OWED_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic pending
);

  localparam logic [OWED_W-1:0] OWED_MAX = {OWED_W{1'b1}};

  logic [OWED_W-1:0] owed_q;
  logic [OWED_W-1:0] owed_d;
  logic              owed_en;

  always_comb begin
    owed_d  = owed_q;
    owed_en = 1'b0;
    unique case ({inc, dec})
      2'b10: begin
        if (owed_q != OWED_MAX) begin
          owed_d  = owed_q + OWED_W'(1);
          owed_en = 1'b1;
        end
      end
      2'b01: begin
        if (owed_q != '0) begin
          owed_d  = owed_q - OWED_W'(1);
          owed_en = 1'b1;
        end
      end
      default: begin
        owed_d  = owed_q;
        owed_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       owed_q <= '0;
    else if (owed_en) owed_q <= owed_d;
  end

  assign pending = (owed_q != '0);

endmodule

// File: rtl/refresh_rowctr.sv
module refresh_rowctr #(
  parameter int unsigned ROWS = 8192,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);

  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_d;

  generate
    if ((ROWS & (ROWS - 1)) == 0) begin : g_pow2
      assign row_d = row_q + ROW_W'(1);
    end else begin : g_mod
      assign row_d = (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + ROW_W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row_q <= '0;
    else if (adv) row_q <= row_d;
  end

  assign row = row_q;

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int unsigned ROWS          = 8192,
  parameter int unsigned RETENTION_CYC = 3000000,
  parameter int unsigned OWED_W        = 2,
  localparam int unsigned ROW_W        = $clog2(ROWS),
  localparam int unsigned INTERVAL     = interval_of(RETENTION_CYC, ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             ref_req,
  output logic [ROW_W-1:0] ref_row,
  input  logic             ref_grant,
  input  logic             ref_done,
  output logic             wr_block
);

  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic  expire;
  logic  pending;
  logic  start;
  logic  finish;
  slot_e slot_q;
  slot_e slot_d;

  refresh_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .expire (expire)
  );

  refresh_owed #(.OWED_W(OWED_W)) u_owed (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .inc     (expire),
    .dec     (finish),
    .pending (pending)
  );

  refresh_rowctr #(.ROWS(ROWS)) u_row (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (finish),
    .row   (ref_row)
  );

  always_comb begin
    start  = (slot_q == SLOT_IDLE) && pending && ref_grant;
    finish = (slot_q == SLOT_BUSY) && ref_done;
    slot_d = slot_q;
    if (start)  slot_d = SLOT_BUSY;
    if (finish) slot_d = SLOT_IDLE;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) slot_q <= SLOT_IDLE;
    else             slot_q <= slot_d;
  end

  assign ref_req  = pending && (slot_q == SLOT_IDLE);
  assign wr_block = (slot_q == SLOT_BUSY);

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int unsigned ROWS  = 8192,
  parameter int unsigned ROW_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_req,
  input logic [ROW_W-1:0] ref_row,
  input logic             ref_grant,
  input logic             ref_done,
  input logic             wr_block
);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_grant) |=> (ref_req && $stable(ref_row)));

  assert_grant_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_grant) |=> (!ref_req && wr_block));

  assert_block_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_block && !ref_done) |=> wr_block);

  assert_block_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_block && ref_done) |=> !wr_block);

  assert_row_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_block && ref_done) |=> $stable(ref_row));

  assert_row_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_block && ref_done) |=>
      (ref_row == (($past(ref_row) == ROW_W'(ROWS - 1)) ? '0 : $past(ref_row) + ROW_W'(1))));

  assert_stray_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_req && !wr_block) |=> !wr_block);

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_req && wr_block));

  always_ff @(posedge clk) begin
    if (rst_n) begin
      assert_row_range_R6: assert (32'(ref_row) < ROWS);
    end
  end

endmodule

bind refresh_sched refresh_sched_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_req   (ref_req),
  .ref_row   (ref_row),
  .ref_grant (ref_grant),
  .ref_done  (ref_done),
  .wr_block  (wr_block)
);

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS       = 4;
  localparam int RET_CYC    = 40;
  localparam int IVL        = RET_CYC / ROWS;
  localparam int SYNC       = 2;
  localparam int ROW_W      = $clog2(ROWS);
  localparam int FIRST      = SYNC + IVL;

  logic             clk;
  logic             rst_n;
  logic             ref_req;
  logic [ROW_W-1:0] ref_row;
  logic             ref_grant;
  logic             ref_done;
  logic             wr_block;

  int ecount;
  int vectors;
  int misses;
  bit reported;

  refresh_sched #(.ROWS(ROWS), .RETENTION_CYC(RET_CYC), .OWED_W(2)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_req   (ref_req),
    .ref_row   (ref_row),
    .ref_grant (ref_grant),
    .ref_done  (ref_done),
    .wr_block  (wr_block)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, ecount, act, exp);
    end
  endtask

  task automatic wait_edge(input int n);
    while (ecount < n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  // R1, R2: reset state and first expiry timing
  task automatic t_reset_and_first();
    rst_n = 1'b0; ref_grant = 1'b0; ref_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 req in reset", int'(ref_req), 0);
    check("R1 row in reset", int'(ref_row), 0);
    check("R1 block in reset", int'(wr_block), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req after release", int'(ref_req), 0);
    wait_edge(FIRST - 1);
    check("R2 no req one edge early", int'(ref_req), 0);
    wait_edge(FIRST);
    check("R2 req on first expiry", int'(ref_req), 1);
    check("R2 row 0 first", int'(ref_row), 0);
  endtask

  // R3, R4, R5, R9: prompt service and stray pulses
  task automatic t_prompt_service();
    wait_edge(FIRST + 2);
    check("R3 req held", int'(ref_req), 1);
    check("R3 row held", int'(ref_row), 0);
    ref_grant = 1'b1;
    wait_edge(FIRST + 3);
    ref_grant = 1'b0;
    check("R4 req drops on grant", int'(ref_req), 0);
    check("R4 block raised", int'(wr_block), 1);
    wait_edge(FIRST + 5);
    check("R4 block held", int'(wr_block), 1);
    check("R5 row unchanged mid-cycle", int'(ref_row), 0);
    ref_done = 1'b1;
    wait_edge(FIRST + 6);
    ref_done = 1'b0;
    check("R4 block cleared", int'(wr_block), 0);
    check("R5 row advanced", int'(ref_row), 1);
    check("R5 no req when none owed", int'(ref_req), 0);
    ref_grant = 1'b1;
    wait_edge(FIRST + 7);
    ref_grant = 1'b0;
    check("R9 stray grant no block", int'(wr_block), 0);
    ref_done = 1'b1;
    wait_edge(FIRST + 8);
    ref_done = 1'b0;
    check("R5 stray done row kept", int'(ref_row), 1);
    check("R5 stray done no req", int'(ref_req), 0);
  endtask

  task automatic serve_one(input int at_edge, input int exp_row, input int exp_req,
                           input string tag);
    ref_grant = 1'b1;
    wait_edge(at_edge);
    ref_grant = 1'b0;
    check({tag, " block"}, int'(wr_block), 1);
    ref_done = 1'b1;
    wait_edge(at_edge + 1);
    ref_done = 1'b0;
    check({tag, " row"}, int'(ref_row), exp_row);
    check({tag, " req"}, int'(ref_req), exp_req);
  endtask

  // R6, R7, R8: backlog, saturation, wrap
  task automatic t_backlog();
    wait_edge(FIRST + IVL);
    check("R2 second expiry", int'(ref_req), 1);
    wait_edge(FIRST + 4 * IVL);
    check("R7 req still pending", int'(ref_req), 1);
    check("R3 row held under backlog", int'(ref_row), 1);
    serve_one(FIRST + 4 * IVL + 1, 2, 1, "R7 owed re-raise");
    serve_one(FIRST + 4 * IVL + 3, 3, 1, "R7 owed second");
    serve_one(FIRST + 4 * IVL + 5, 0, 0, "R8 saturated R6 wrap");
    wait_edge(FIRST + 5 * IVL - 1);
    check("R2 no req before period", int'(ref_req), 0);
    wait_edge(FIRST + 5 * IVL);
    check("R2 periodic expiry", int'(ref_req), 1);
    check("R6 row after wrap", int'(ref_row), 0);
  endtask

  // R7: done in the same cycle as an expiry
  task automatic t_coincide();
    ref_grant = 1'b1;
    wait_edge(FIRST + 5 * IVL + 1);
    ref_grant = 1'b0;
    check("R4 block for coincide", int'(wr_block), 1);
    wait_edge(FIRST + 6 * IVL - 1);
    check("R4 block long cycle", int'(wr_block), 1);
    ref_done = 1'b1;
    wait_edge(FIRST + 6 * IVL);
    ref_done = 1'b0;
    check("R7 coincide req", int'(ref_req), 1);
    check("R7 coincide row", int'(ref_row), 1);
    check("R7 coincide block", int'(wr_block), 0);
  endtask

  initial begin
    vectors = 0; misses = 0; reported = 1'b0;
    t_reset_and_first();
    t_prompt_service();
    t_backlog();
    t_coincide();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 5000);
    vectors++;
    misses++;
    $display("FAIL watchdog expired: actual hung expected finished");
    finish_run();
  end

endmodule